// File: doc/BRIEF.md
# Flat Panel Line and Frame Timing Generator

This block produces the horizontal and vertical timing for a flat panel. A pixel counter steps through the active pixels of each line and then through a horizontal blanking interval. In thin-film-transistor (TFT) mode, a line-sync pulse fires inside that blanking interval, at a programmed offset after the last active pixel. A line counter steps through the panel lines up to a programmed vertical size and then wraps. A one-cycle strobe marks the first pixel of every frame.

Software programs the timing through a byte-wide write port at five addresses, and reads the values back through a combinational read port. The horizontal fields are kept in units of 8 pixels, each with a fixed bias. The active width arrives as a separate input in pixels.

Every timing value, including the active width, is copied into a shadow set at the frame boundary. A frame therefore always runs on one consistent set of values. A configuration-error flag shows when the programmed pulse offset is larger than the programmed blanking length.

Top module: `lcdt_line_timing`

## Requirements
- R1: The vertical size is a 10-bit value. Address 0 holds bits 7-0. Bits 1-0 of address 1 hold size bits 9-8. Reading address 1 returns zeros in bits 7-2.
- R2: The other writable fields are at these addresses. Address 2 bits 4-0 hold the pulse offset field. Address 3 bits 4-0 hold the blanking field. Address 4 bit 0 holds the TFT mode flag. All other bits read back as zero. Unmapped addresses 5-7 read as zero.
- R3: One line lasts A + (blanking field + 4) × 8 clock cycles, where A is the active width. pixelX counts from 0 up to one less than the line length, then returns to 0.
- R4: dataEn is high exactly when pixelX < A. A is activeWidth with its low three bits cleared.
- R5: In TFT mode, linePulse is high for exactly 8 cycles. It starts at pixelX = A + (pulse offset field + 2) × 8. It never overlaps dataEn.
- R6: With the TFT flag clear, linePulse stays low.
- R7: lineY holds its value within a line, advances at each line wrap, and returns to 0 after the line equal to the vertical size. A frame therefore has vertical size + 1 lines.
- R8: frameStart is high for exactly the one cycle in which pixelX = 0 and lineY = 0. This includes the state directly after reset.
- R9: cfgError is high exactly when the programmed pulse offset field is greater than the programmed blanking field. It follows register writes on the next cycle.
- R10: Register values and activeWidth take effect only at the first cycle of a frame. A write made in the last cycle of a frame takes effect one frame later still.
- R11: After reset, the vertical size is 3, both horizontal fields are 0, the TFT flag is 1 and the shadow active width is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 3 | Register address, used for both write and read |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| activeWidth | input | ACT_W (11) | Active pixels per line; the low 3 bits are ignored |
| dataEn | output | 1 | High during active pixels |
| linePulse | output | 1 | Active-high line sync, TFT mode only |
| frameStart | output | 1 | One-cycle strobe at line 0, pixel 0 |
| cfgError | output | 1 | Pulse offset field is greater than the blanking field |
| pixelX | output | PX_W (12) | Pixel position within the line |
| lineY | output | 10 | Line position within the frame |

## Verification
A register write and the shadow load can fall on the same clock edge: the last cycle of a frame, when the live values are copied for the next frame. The bench waits for the last pixel of the last line and issues the write on that exact edge. It then checks two things. The frame that follows must still run on the previous offset and size. The new values must appear only in the frame after that. A reference model is compared on every clock, so a pulse position or line count that is one frame early shows up as a mismatch at the first differing cycle.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  // Register addresses
  localparam logic [2:0] ADDR_VSIZE_LO = 3'd0;
  localparam logic [2:0] ADDR_VSIZE_HI = 3'd1;
  localparam logic [2:0] ADDR_PULSE    = 3'd2;
  localparam logic [2:0] ADDR_BLANK    = 3'd3;
  localparam logic [2:0] ADDR_MODE     = 3'd4;

  localparam int FIELD_W    = 5;
  localparam int UNIT_SHIFT = 3;  // 8-pixel units
  localparam int PULSE_BIAS = 2;
  localparam int BLANK_BIAS = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic lineEnd;
    logic frameEnd;
    logic frameHead;
  } lcdtStrobeT;

endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
#(
  parameter int          LN_W      = 10,
  parameter logic [9:0]  DEF_VSIZE = 10'd3,
  parameter logic [4:0]  DEF_PULSE = 5'd0,
  parameter logic [4:0]  DEF_BLANK = 5'd0,
  parameter logic        DEF_TFT   = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  output logic [LN_W-1:0]    liveVsize,
  output logic [FIELD_W-1:0] livePulse,
  output logic [FIELD_W-1:0] liveBlank,
  output logic               liveTft,
  output logic               cfgError
);

  localparam int HI_W = LN_W - 8;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveVsize <= LN_W'(DEF_VSIZE);
      livePulse <= DEF_PULSE;
      liveBlank <= DEF_BLANK;
      liveTft   <= DEF_TFT;
      cfgError  <= (DEF_PULSE > DEF_BLANK);
    end else begin
      if (regWrEn) begin
        unique case (regAddr)
          ADDR_VSIZE_LO: liveVsize[7:0]      <= regWrData;
          ADDR_VSIZE_HI: liveVsize[LN_W-1:8] <= regWrData[HI_W-1:0];
          ADDR_PULSE:    livePulse           <= regWrData[FIELD_W-1:0];
          ADDR_BLANK:    liveBlank           <= regWrData[FIELD_W-1:0];
          ADDR_MODE:     liveTft             <= regWrData[0];
          default: ;
        endcase
      end
      // registered error flag, computed from next-state values
      cfgError <= (nextPulse > nextBlank);
    end
  end

  logic [FIELD_W-1:0] nextPulse;
  logic [FIELD_W-1:0] nextBlank;

  always_comb begin
    nextPulse = livePulse;
    nextBlank = liveBlank;
    if (regWrEn && regAddr == ADDR_PULSE) nextPulse = regWrData[FIELD_W-1:0];
    if (regWrEn && regAddr == ADDR_BLANK) nextBlank = regWrData[FIELD_W-1:0];
  end

  always_comb begin
    regRdData = 8'h00;
    unique case (regAddr)
      ADDR_VSIZE_LO: regRdData = liveVsize[7:0];
      ADDR_VSIZE_HI: regRdData[HI_W-1:0] = liveVsize[LN_W-1:8];
      ADDR_PULSE:    regRdData[FIELD_W-1:0] = livePulse;
      ADDR_BLANK:    regRdData[FIELD_W-1:0] = liveBlank;
      ADDR_MODE:     regRdData[0] = liveTft;
      default:       regRdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
#(
  parameter int PX_W = 12,
  parameter int LN_W = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PX_W-1:0] lineLen,
  input  logic [LN_W-1:0] vsize,
  output logic [PX_W-1:0] pixelX,
  output logic [LN_W-1:0] lineY,
  output lcdtStrobeT      strb
);

  always_comb begin
    strb.lineEnd   = (pixelX == lineLen - PX_W'(1));
    strb.frameEnd  = strb.lineEnd && (lineY == vsize);
    strb.frameHead = (pixelX == '0) && (lineY == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixelX <= '0;
      lineY  <= '0;
    end else if (strb.lineEnd) begin
      pixelX <= '0;
      lineY  <= strb.frameEnd ? '0 : lineY + LN_W'(1);
    end else begin
      pixelX <= pixelX + PX_W'(1);
    end
  end

endmodule

// File: rtl/lcdt_dp.sv
module lcdt_dp
  import lcdt_pkg::*;
#(
  parameter int          ACT_W     = 11,
  parameter int          PX_W      = 12,
  parameter int          LN_W      = 10,
  parameter logic [9:0]  DEF_VSIZE = 10'd3,
  parameter logic [4:0]  DEF_PULSE = 5'd0,
  parameter logic [4:0]  DEF_BLANK = 5'd0,
  parameter logic        DEF_TFT   = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  lcdtStrobeT         strb,
  input  logic [PX_W-1:0]    pixelX,
  input  logic [ACT_W-1:0]   activeWidth,
  input  logic [LN_W-1:0]    liveVsize,
  input  logic [FIELD_W-1:0] livePulse,
  input  logic [FIELD_W-1:0] liveBlank,
  input  logic               liveTft,
  output logic [PX_W-1:0]    lineLen,
  output logic [LN_W-1:0]    shVsize,
  output logic               dataEn,
  output logic               linePulse,
  output logic               frameStart
);

  logic [FIELD_W-1:0] shPulse;
  logic [FIELD_W-1:0] shBlank;
  logic               shTft;
  logic [ACT_W-1:0]   shAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shVsize <= LN_W'(DEF_VSIZE);
      shPulse <= DEF_PULSE;
      shBlank <= DEF_BLANK;
      shTft   <= DEF_TFT;
      shAct   <= '0;
    end else if (strb.frameEnd) begin
      shVsize <= liveVsize;
      shPulse <= livePulse;
      shBlank <= liveBlank;
      shTft   <= liveTft;
      shAct   <= {activeWidth[ACT_W-1:UNIT_SHIFT], {UNIT_SHIFT{1'b0}}};
    end
  end

  logic [PX_W-1:0] actPx;
  logic [PX_W-1:0] blankPx;
  logic [PX_W-1:0] pulseLead;
  logic [PX_W-1:0] pulseTail;

  always_comb begin
    actPx     = PX_W'(shAct);
    blankPx   = PX_W'(shBlank + FIELD_W'(BLANK_BIAS)) << UNIT_SHIFT;
    lineLen   = actPx + blankPx;
    pulseLead = actPx + (PX_W'(PX_W'(shPulse) + PX_W'(PULSE_BIAS)) << UNIT_SHIFT);
    pulseTail = pulseLead + PX_W'(1 << UNIT_SHIFT);
  end

  assign dataEn     = (pixelX < actPx);
  assign linePulse  = shTft && (pixelX >= pulseLead) && (pixelX < pulseTail);
  assign frameStart = strb.frameHead;

endmodule

// File: rtl/lcdt_line_timing.sv
module lcdt_line_timing
  import lcdt_pkg::*;
#(
  parameter int          ACT_W     = 11,
  parameter logic [9:0]  DEF_VSIZE = 10'd3,
  parameter logic [4:0]  DEF_PULSE = 5'd0,
  parameter logic [4:0]  DEF_BLANK = 5'd0,
  parameter logic        DEF_TFT   = 1'b1,
  localparam int         PX_W      = ACT_W + 1,
  localparam int         LN_W      = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic [ACT_W-1:0] activeWidth,
  output logic             dataEn,
  output logic             linePulse,
  output logic             frameStart,
  output logic             cfgError,
  output logic [PX_W-1:0]  pixelX,
  output logic [LN_W-1:0]  lineY
);

  logic [LN_W-1:0]    liveVsize;
  logic [FIELD_W-1:0] livePulse;
  logic [FIELD_W-1:0] liveBlank;
  logic               liveTft;
  logic [PX_W-1:0]    lineLen;
  logic [LN_W-1:0]    shVsize;
  lcdtStrobeT         strb;

  lcdt_regs #(
    .LN_W(LN_W), .DEF_VSIZE(DEF_VSIZE), .DEF_PULSE(DEF_PULSE),
    .DEF_BLANK(DEF_BLANK), .DEF_TFT(DEF_TFT)
  ) u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .liveVsize(liveVsize),
    .livePulse(livePulse), .liveBlank(liveBlank), .liveTft(liveTft),
    .cfgError(cfgError)
  );

  lcdt_ctrl #(.PX_W(PX_W), .LN_W(LN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineLen(lineLen), .vsize(shVsize),
    .pixelX(pixelX), .lineY(lineY), .strb(strb)
  );

  lcdt_dp #(
    .ACT_W(ACT_W), .PX_W(PX_W), .LN_W(LN_W), .DEF_VSIZE(DEF_VSIZE),
    .DEF_PULSE(DEF_PULSE), .DEF_BLANK(DEF_BLANK), .DEF_TFT(DEF_TFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pixelX(pixelX),
    .activeWidth(activeWidth), .liveVsize(liveVsize), .livePulse(livePulse),
    .liveBlank(liveBlank), .liveTft(liveTft), .lineLen(lineLen),
    .shVsize(shVsize), .dataEn(dataEn), .linePulse(linePulse),
    .frameStart(frameStart)
  );

endmodule

// File: rtl/lcdt_line_timing_chk.sv
module lcdt_line_timing_chk #(
  parameter int PX_W = 12,
  parameter int LN_W = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic            dataEn,
  input logic            linePulse,
  input logic            frameStart,
  input logic [PX_W-1:0] pixelX,
  input logic [LN_W-1:0] lineY
);

  p_px_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pixelX != '0) |-> (pixelX == $past(pixelX) + PX_W'(1)));

  p_line_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pixelX != '0) |-> $stable(lineY));

  p_pulse_blank_r5: assert property (@(posedge clk) disable iff (!rstN)
    linePulse |-> !dataEn);

  p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linePulse) |=> linePulse);

  p_fs_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

endmodule

bind lcdt_line_timing lcdt_line_timing_chk #(.PX_W(PX_W), .LN_W(LN_W)) u_chk (
  .clk(clk), .rstN(rstN), .dataEn(dataEn), .linePulse(linePulse),
  .frameStart(frameStart), .pixelX(pixelX), .lineY(lineY)
);

// File: tb/tb_lcdt_line_timing.sv
`timescale 1ns/1ps
module tb_lcdt_line_timing;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic [10:0] activeWidth = 11'd64;
  logic        dataEn, linePulse, frameStart, cfgError;
  logic [11:0] pixelX;
  logic [9:0]  lineY;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  string phaseTag = "";

  always #5 clk = ~clk;

  lcdt_line_timing dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .activeWidth(activeWidth),
    .dataEn(dataEn), .linePulse(linePulse), .frameStart(frameStart),
    .cfgError(cfgError), .pixelX(pixelX), .lineY(lineY)
  );

  // Reference model: live registers, shadows and counters as integers
  int lv = 3, lp = 0, lb = 0, lt = 1;
  int sv = 3, sp = 0, sb = 0, st = 1, sa = 0;
  int mx = 0, my = 0;
  bit mErr = 0;

  function automatic int lineLenM();
    return sa + (sb + 4) * 8;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      lv = 3; lp = 0; lb = 0; lt = 1;
      sv = 3; sp = 0; sb = 0; st = 1; sa = 0;
      mx = 0; my = 0; mErr = 0;
    end else begin
      if (mx == lineLenM() - 1) begin
        mx = 0;
        if (my == sv) begin
          my = 0;
          sv = lv; sp = lp; sb = lb; st = lt;
          sa = (int'(activeWidth) / 8) * 8;
        end else my = my + 1;
      end else mx = mx + 1;
      if (regWrEn) begin
        case (regAddr)
          3'd0: lv = (lv & 32'h300) | int'(regWrData);
          3'd1: lv = (lv & 32'h0FF) | ((int'(regWrData) & 3) << 8);
          3'd2: lp = int'(regWrData) & 31;
          3'd3: lb = int'(regWrData) & 31;
          3'd4: lt = int'(regWrData) & 1;
          default: ;
        endcase
      end
      mErr = (lp > lb);
    end
  end

  function automatic int expRd(input int a);
    case (a)
      0: return lv & 255;
      1: return lv >> 8;
      2: return lp;
      3: return lb;
      4: return lt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s%s %s at %0t: actual %0d expected %0d",
               req, phaseTag, what, $time, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int ps;
      bit eLp;
      ps = sa + (sp + 2) * 8;
      eLp = (st == 1) && (mx >= ps) && (mx < ps + 8);
      chk(int'(pixelX) == mx, "R3", "pixelX", int'(pixelX), mx);
      chk(int'(lineY) == my, "R7", "lineY", int'(lineY), my);
      chk(dataEn == (mx < sa), "R4", "dataEn", int'(dataEn), int'(mx < sa));
      chk(linePulse == eLp, st ? "R5" : "R6", "linePulse", int'(linePulse), int'(eLp));
      chk(frameStart == (mx == 0 && my == 0), "R8", "frameStart",
          int'(frameStart), int'(mx == 0 && my == 0));
      chk(cfgError == mErr, "R9", "cfgError", int'(cfgError), int'(mErr));
      chk(int'(regRdData) == expRd(int'(regAddr)), (regAddr < 2) ? "R1" : "R2",
          "regRdData", int'(regRdData), expRd(int'(regAddr)));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); #1;
    regAddr = a;
    @(negedge clk);
  endtask

  task automatic waitFrameHead();
    do @(negedge clk); while (!(mx == 0 && my == 0));
  endtask

  task automatic waitFrameLast();
    do @(negedge clk); while (!(mx == lineLenM() - 1 && my == sv));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R11: reset state seen through the ports while reset is held
    chk(frameStart == 1'b1, "R11", "frameStart in reset", int'(frameStart), 1);
    chk(dataEn == 1'b0, "R11", "dataEn in reset", int'(dataEn), 0);
    chk(lineY == 10'd0, "R11", "lineY in reset", int'(lineY), 0);
    regAddr = 3'd0;
    #1;
    chk(regRdData == 8'h03, "R11", "vsize lo default", int'(regRdData), 3);
    regAddr = 3'd4;
    #1;
    chk(regRdData == 8'h01, "R11", "tft default", int'(regRdData), 1);
    @(negedge clk); #1;
    rstN = 1'b1;

    repeat (300) @(negedge clk);
    // Reads of every address, including unmapped ones (R1, R2)
    for (int a = 0; a < 8; a++) rd(3'(a));

    // Program within one frame (R1, R2, R5)
    waitFrameHead();
    wr(3'd2, 8'hE1);
    wr(3'd3, 8'hE3);
    wr(3'd4, 8'hFF);
    rd(3'd2); rd(3'd3); rd(3'd4);
    wr(3'd1, 8'hFE);
    rd(3'd1);                 // R1: reads 02
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h05);
    rd(3'd0);
    waitFrameHead();
    waitFrameHead();

    // TFT off (R6)
    wr(3'd4, 8'h00);
    waitFrameHead(); waitFrameHead();

    // Offset larger than blanking (R9), then clear
    wr(3'd2, 8'h05);
    repeat (50) @(negedge clk);
    wr(3'd4, 8'h01);
    waitFrameHead(); waitFrameHead();
    wr(3'd3, 8'h07);
    waitFrameHead();

    // Active width with low bits set (R4)
    @(negedge clk); #1;
    activeWidth = 11'd45;
    waitFrameHead(); waitFrameHead();

    // R10: write on the shadow-load edge
    phaseTag = "/R10";
    waitFrameLast(); #1;
    regWrEn = 1'b1; regAddr = 3'd2; regWrData = 8'h02;
    @(negedge clk); #1;
    regWrEn = 1'b0;
    waitFrameLast(); #1;
    regWrEn = 1'b1; regAddr = 3'd0; regWrData = 8'h01;
    @(negedge clk); #1;
    regWrEn = 1'b0;
    waitFrameHead(); waitFrameHead(); waitFrameHead();
    phaseTag = "";

    // Single-line frames (R7, R8)
    wr(3'd0, 8'h00);
    waitFrameHead();
    repeat (6) waitFrameHead();

    finished = 1'b1;
    summary();
  end

endmodule